// File: doc/BRIEF.md
# Serial NOR Flash Write-Protect Unit

This block keeps the status byte of a serial NOR flash device and decides, one request at a time, whether a program or erase may touch the array. An upstream command decoder hands it one strobe per cycle: set or clear the write-enable latch, load the status byte, read the status byte, program, sector erase or whole-array erase. Program and sector erase carry the 64 KiB sector number of their target. The block also samples the active-low write-protect pin.

Each program or erase request produces a one-cycle response that grants or refuses it. Refusal comes from a cleared write-enable latch or from a protected region. A four-bit protect level picks a power-of-two number of sectors. One further status bit places that region at the top or at the bottom of the array. A status read returns the byte one cycle after the request. Writes to the status byte can be locked by combining a lock bit with a low level on the protect pin.

Top module: `nor_wp_unit`

## Requirements
- R1: After reset every status bit reads 0, and neither response output pulses until a command arrives.
- R2: Op code 1 sets the write-enable latch (status bit 1). Op code 2 clears it.
- R3: Op code 3, issued with the latch set, loads status bits 7:2 from data bits 7:2 when the protect pin is high, whatever bit 7 holds. It does the same when bit 7 is 0, whatever the pin level. Bit 0 always reads 0.
- R4: Op code 3 leaves bits 7:2 unchanged when the protect pin is low and bit 7 (the lock bit) is 1.
- R5: Op code 3 with the latch clear leaves bits 7:2 unchanged.
- R6: The latch clears after every op code 3, 5, 6 or 7, whether that command took effect or was refused.
- R7: A program (op 5), sector erase (op 6) or bulk erase (op 7) issued with the latch clear is refused.
- R8: The protect level is n = {bit 6, bit 4, bit 3, bit 2}. It protects no sectors for n = 0, and otherwise min(2^(n-1), sector count) sectors, with a default sector count of 512. With bit 5 at 0 the protected sectors are the highest-numbered ones, ending at the last sector. With bit 5 at 1 they start at sector 0. A program or sector erase with the latch set is granted exactly when its sector lies outside the region.
- R9: A bulk erase with the latch set is granted only when n = 0.
- R10: Op code 4 returns the status byte, as it stood when the request was taken, on rd_data_o with rd_valid_o high one cycle later. A program or erase answers on resp_valid_o and resp_grant_o one cycle after the request. Op code 0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command strobe is present this cycle |
| cmd_op_i | input | 3 | Command op code (see R2 to R10) |
| cmd_data_i | input | 8 | Data byte for a status load |
| cmd_sector_i | input | SECT_W (9) | 64 KiB sector number of the target |
| wp_n_i | input | 1 | Write-protect pin, active low |
| rd_valid_o | output | 1 | Status read result is valid |
| rd_data_o | output | 8 | Status byte returned by a read |
| resp_valid_o | output | 1 | Program or erase decision is valid |
| resp_grant_o | output | 1 | 1 grants the request, 0 refuses it |

## Verification
The lock logic is driven through all four combinations of pin level and lock bit, and a refused load must leave bits 7:2 intact while still clearing the latch. Every protect level from 0 to 15 is combined with both placements of the region. For each pair, requests go to the first and last sectors, to the middle of the array and to the sectors on either side of the region edge. This separates an off-by-one edge, a swapped top and bottom, and a missing cap at the array size. Requests with the latch clear and bulk erases at zero and nonzero levels show that refusal for a missing enable is kept apart from refusal for protection.

// File: rtl/nor_wp_pkg.sv
package nor_wp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_WRSR   = 3'd3,
    OP_RDSR   = 3'd4,
    OP_PROG   = 3'd5,
    OP_SERASE = 3'd6,
    OP_BERASE = 3'd7
  } wp_op_e;

  // status byte bit positions
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_LV0  = 2;
  localparam int unsigned ST_LV2  = 4;
  localparam int unsigned ST_TB   = 5;
  localparam int unsigned ST_LV3  = 6;
  localparam int unsigned ST_LOCK = 7;

  // bits a status load may change
  localparam logic [7:0] ST_WR_MASK = 8'hFC;

endpackage

// File: rtl/nor_wp_status.sv
module nor_wp_status
  import nor_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  wp_op_e     cmd_op_i,
  input  logic [7:0] cmd_data_i,
  input  logic       wp_n_i,
  output logic [7:0] status_o
);

  logic [7:0] st_q, st_d;
  logic       st_en;
  logic       wr_allowed;

  assign st_en      = cmd_valid_i;
  assign wr_allowed = st_q[ST_WEL] && (wp_n_i || !st_q[ST_LOCK]);

  always_comb begin
    st_d = st_q;
    unique case (cmd_op_i)
      OP_WREN: st_d[ST_WEL] = 1'b1;
      OP_WRDI: st_d[ST_WEL] = 1'b0;
      OP_WRSR: begin
        if (wr_allowed) st_d = (cmd_data_i & ST_WR_MASK) | (st_q & ~ST_WR_MASK);
        st_d[ST_WEL] = 1'b0;
      end
      OP_PROG, OP_SERASE, OP_BERASE: st_d[ST_WEL] = 1'b0;
      default: ;
    endcase
    st_d[ST_BUSY] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status_o = st_q;

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WREN) |=> status_o[ST_WEL]);

  assert_wrdi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRDI) |=> !status_o[ST_WEL]);

  assert_locked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRSR && !wp_n_i && status_o[ST_LOCK])
      |=> $stable(status_o[7:2]));

  assert_load_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRSR && !status_o[ST_WEL])
      |=> $stable(status_o[7:2]));

  assert_wel_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (cmd_op_i == OP_WRSR || cmd_op_i == OP_PROG ||
                     cmd_op_i == OP_SERASE || cmd_op_i == OP_BERASE))
      |=> !status_o[ST_WEL]);

endmodule

// File: rtl/nor_wp_region.sv
module nor_wp_region #(
  parameter int unsigned SECT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        level_i,
  input  logic              bottom_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              prot_o
);

  localparam logic [SECT_W:0] ONE    = (SECT_W+1)'(1);
  localparam logic [SECT_W:0] NSECT  = ONE << SECT_W;
  localparam logic [4:0]      SH_CAP = 5'(SECT_W);

  logic [4:0]      shift;
  logic [SECT_W:0] count;
  logic [SECT_W:0] sec_ext;

  assign shift   = {1'b0, level_i} - 5'd1;
  assign sec_ext = {1'b0, sector_i};

  always_comb begin
    if (level_i == 4'd0)      count = '0;
    else if (shift >= SH_CAP) count = NSECT;
    else                      count = ONE << shift;
  end

  assign prot_o = bottom_i ? (sec_ext < count) : (sec_ext >= (NSECT - count));

  assert_level0_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == 4'd0) |-> !prot_o);

  assert_edge_sectors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i != 4'd0 && sector_i == (bottom_i ? '0 : '1)) |-> prot_o);

endmodule

// File: rtl/nor_wp_gate.sv
module nor_wp_gate
  import nor_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  wp_op_e     cmd_op_i,
  input  logic [7:0] status_i,
  input  logic       prot_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       resp_valid_o,
  output logic       resp_grant_o
);

  logic       is_rd, is_pe, level_nz, grant_d;
  logic       rd_vld_q, rsp_vld_q, rsp_gnt_q;
  logic [7:0] rd_dat_q;

  assign is_rd    = cmd_valid_i && cmd_op_i == OP_RDSR;
  assign is_pe    = cmd_valid_i && (cmd_op_i == OP_PROG || cmd_op_i == OP_SERASE ||
                                    cmd_op_i == OP_BERASE);
  assign level_nz = status_i[ST_LV3] || (status_i[ST_LV2:ST_LV0] != 3'd0);

  always_comb begin
    grant_d = 1'b0;
    if (status_i[ST_WEL]) begin
      if (cmd_op_i == OP_BERASE) grant_d = !level_nz;
      else                       grant_d = !prot_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rsp_vld_q <= 1'b0;
      rsp_gnt_q <= 1'b0;
    end else begin
      rd_vld_q  <= is_rd;
      rsp_vld_q <= is_pe;
      rsp_gnt_q <= is_pe && grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_dat_q <= '0;
    else if (is_rd) rd_dat_q <= status_i;
  end

  assign rd_valid_o   = rd_vld_q;
  assign rd_data_o    = rd_dat_q;
  assign resp_valid_o = rsp_vld_q;
  assign resp_grant_o = rsp_gnt_q;

  assert_no_wel_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pe && !status_i[ST_WEL]) |=> (resp_valid_o && !resp_grant_o));

  assert_bulk_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_BERASE && level_nz) |=> !resp_grant_o);

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && resp_valid_o));

  assert_grant_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant_o |-> resp_valid_o);

endmodule

// File: rtl/nor_wp_unit.sv
module nor_wp_unit
  import nor_wp_pkg::*;
#(
  parameter int unsigned SECT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [7:0]        cmd_data_i,
  input  logic [SECT_W-1:0] cmd_sector_i,
  input  logic              wp_n_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              resp_valid_o,
  output logic              resp_grant_o
);

  wp_op_e     op;
  logic [7:0] status;
  logic [3:0] level;
  logic       prot;

  assign op    = wp_op_e'(cmd_op_i);
  assign level = {status[ST_LV3], status[ST_LV2:ST_LV0]};

  nor_wp_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (op),
    .cmd_data_i  (cmd_data_i),
    .wp_n_i      (wp_n_i),
    .status_o    (status)
  );

  nor_wp_region #(.SECT_W(SECT_W)) u_region (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level),
    .bottom_i (status[ST_TB]),
    .sector_i (cmd_sector_i),
    .prot_o   (prot)
  );

  nor_wp_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (op),
    .status_i     (status),
    .prot_i       (prot),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .resp_valid_o (resp_valid_o),
    .resp_grant_o (resp_grant_o)
  );

endmodule

// File: tb/tb_nor_wp_unit.sv
module tb_nor_wp_unit;

  localparam int SECT_W = 9;
  localparam int NSECT  = 1 << SECT_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [7:0]        cmd_data;
  logic [SECT_W-1:0] cmd_sector;
  logic              wp_n;
  logic              rd_valid, resp_valid, resp_grant;
  logic [7:0]        rd_data;

  always #2 clk = ~clk;

  nor_wp_unit #(.SECT_W(SECT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_sector_i(cmd_sector), .wp_n_i(wp_n),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .resp_valid_o(resp_valid), .resp_grant_o(resp_grant)
  );

  typedef struct {
    bit         is_rd;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       exp_q[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] m_st;

  function automatic int m_count(int lvl);
    int c = 0;
    if (lvl > 0) begin
      c = 1;
      for (int i = 1; i < lvl; i++) if (c < NSECT) c = c * 2;
    end
    if (c > NSECT) c = NSECT;
    return c;
  endfunction

  function automatic bit m_prot(int lvl, bit bot, int sec);
    int c = m_count(lvl);
    return bot ? (sec < c) : (sec >= NSECT - c);
  endfunction

  // reference model plus driver: one command per cycle
  task automatic issue(input int op, input logic [7:0] d, input int sec, input string req);
    exp_t e;
    int   lvl;
    bit   g;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_data = d; cmd_sector = sec[SECT_W-1:0];
    lvl = {m_st[6], m_st[4:2]};
    case (op)
      1: m_st[1] = 1'b1;
      2: m_st[1] = 1'b0;
      3: begin
        if (m_st[1] && (wp_n || !m_st[7])) m_st[7:2] = d[7:2];
        m_st[1] = 1'b0;
      end
      4: begin e.is_rd = 1; e.val = m_st; e.req = req; exp_q.push_back(e); end
      5, 6, 7: begin
        if (op == 7) g = m_st[1] && (lvl == 0);
        else         g = m_st[1] && !m_prot(lvl, m_st[5], sec);
        e.is_rd = 0; e.val = {7'd0, g}; e.req = req; exp_q.push_back(e);
        m_st[1] = 1'b0;
      end
      default: ;
    endcase
    @(posedge clk);
    #1 cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  // monitor: compare results against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (rd_valid || resp_valid)) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result rd=%0b resp=%0b (expected none)", rd_valid, resp_valid);
      end else begin
        e = exp_q.pop_front();
        if (e.is_rd && (!rd_valid || rd_data !== e.val)) begin
          errors++;
          $display("FAIL %s status read: got valid=%0b data=%02h, expected %02h", e.req, rd_valid, rd_data, e.val);
        end else if (!e.is_rd && (!resp_valid || resp_grant !== e.val[0])) begin
          errors++;
          $display("FAIL %s grant: got valid=%0b grant=%0b, expected %0b", e.req, resp_valid, resp_grant, e.val[0]);
        end
      end
    end
  end

  task automatic run_tests();
    int secs[7];
    // R1: reset state
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || resp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs after reset rd=%0b resp=%0b, expected 0 0", rd_valid, resp_valid);
    end
    issue(4, 0, 0, "R1");
    // R2: latch set and clear
    issue(1, 0, 0, "R2"); issue(4, 0, 0, "R2");
    issue(2, 0, 0, "R2"); issue(4, 0, 0, "R2");
    // R7: no latch, all refused
    issue(5, 0, 3, "R7"); issue(6, 0, 3, "R7"); issue(7, 0, 0, "R7");
    // R5: load without latch ignored
    issue(3, 8'hFC, 0, "R5"); issue(4, 0, 0, "R5");
    // R3 / R6: loads with pin high, lock set then cleared
    issue(1, 0, 0, "R3"); issue(3, 8'h83, 0, "R3"); issue(4, 0, 0, "R6");
    issue(1, 0, 0, "R3"); issue(3, 8'h00, 0, "R3"); issue(4, 0, 0, "R3");
    // R3 / R4: pin low
    @(negedge clk); wp_n = 1'b0;
    issue(1, 0, 0, "R3"); issue(3, 8'h80, 0, "R3"); issue(4, 0, 0, "R3");
    issue(1, 0, 0, "R4"); issue(3, 8'h7C, 0, "R4"); issue(4, 0, 0, "R4");
    @(negedge clk); wp_n = 1'b1;
    issue(1, 0, 0, "R3"); issue(3, 8'h00, 0, "R3"); issue(4, 0, 0, "R3");
    // R6: granted program drops latch
    issue(1, 0, 0, "R6"); issue(5, 0, 7, "R6"); issue(4, 0, 0, "R6"); issue(5, 0, 7, "R6");
    // R8 / R9: protect sweep
    for (int bot = 0; bot < 2; bot++) begin
      for (int lvl = 0; lvl < 16; lvl++) begin
        logic [3:0] l4 = lvl[3:0];
        int edge_s = bot ? m_count(lvl) : NSECT - m_count(lvl);
        issue(1, 0, 0, "R8");
        issue(3, {1'b0, l4[3], bot[0], l4[2:0], 2'b00}, 0, "R8");
        issue(4, 0, 0, "R8");
        secs = '{0, 1, NSECT/2 - 1, NSECT/2, NSECT - 1, edge_s - 1, edge_s};
        foreach (secs[k]) begin
          if (secs[k] >= 0 && secs[k] < NSECT) begin
            issue(1, 0, 0, "R8");
            issue((k % 2) ? 6 : 5, 0, secs[k], "R8");
          end
        end
        issue(1, 0, 0, "R9"); issue(7, 0, 0, "R9");
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'd0;
    cmd_sector = '0; wp_n = 1'b1; m_st = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (run did not complete)");
      end
    join_any
    disable fork;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 %0d results missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule